// File: doc/BRIEF.md
# Cascaded Dual Interrupt Request Controller

This block merges two eight-line interrupt controllers, a primary and a secondary, into one sixteen-line request front end. The secondary's output feeds line 2 of the primary. Each line is driven through a single command port. The command can drive the line high or low, or apply a pulse that goes high then low or low then high. Each line can be set to edge or level detection, except for a few lines that are fixed to edge detection.

The block drives one interrupt output toward the processor. It also gives a combinational pending vector with a valid flag, and takes an acknowledge that carries the vector the processor accepted. An acknowledge of a secondary vector is booked on both controllers. The vector bases, the masks, auto-EOI and rotation are plain configuration inputs. A specific end-of-interrupt input clears in-service bits.

A two-state machine controls when requests are re-evaluated. It has two states:
- `ST_IDLE` waits.
- `ST_EVAL` re-evaluates the pending requests.

It has two transitions:
- IDLE→EVAL is taken on any change event: a line command, an acknowledge, an end-of-interrupt, a trigger-mode write, or a mask change.
- EVAL→EVAL is taken when another event arrives during evaluation. EVAL→IDLE is taken otherwise.

In `ST_EVAL` the secondary is examined first. A cascade pulse it produces is visible to the primary in that same evaluation.

Top module: `dual_pic_core`

## Requirements
- R1: `line_op_num[3]` picks the controller (0 primary, 1 secondary) and `line_op_num[2:0]` picks the level. A pending vector is the controller's base with bits 2:0 replaced by the level.
- R2: On an edge-mode line, a low-to-high transition sets the request bit. A set-high command on a line that is already high sets nothing. A set-low command leaves the request bit unchanged.
- R3: On a level-mode line, a high level sets the request bit and a set-low command clears it. An acknowledge does not clear a level-mode request.
- R4: Both trigger-mode registers reset to 0, so every line starts in edge mode. Writes are ANDed with 0xF8 for the primary (`elc_wr_sel`=0) and 0xDE for the secondary (`elc_wr_sel`=1). Bit value 1 means level mode. `elc_rdata` returns the register picked by `elc_rd_sel`.
- R5: When the secondary has an eligible request and its raised flag is clear, the evaluation sets that flag. It also pulses primary line 2, which sets its request. The pending vector then becomes the secondary base plus the secondary's winning level.
- R6: `intr_out` rises on the second rising edge after the event that made a request eligible. It stays high, even if the request goes away, until the edge that takes an acknowledge.
- R7: The search starts at the level one above the priority pointer, which resets to 7, and wraps around. Masked lines (mask bit 1) are skipped. An in-service bit met before any eligible request ends the search with no winner.
- R8: An acknowledge whose bits 7:3 equal the secondary base bits 7:3 is accepted on the secondary at `ack_vector[2:0]`, and also on primary level 2. Any other acknowledge is accepted on the primary at `ack_vector[2:0]`.
- R9: Accepting a level clears that controller's raised flag and clears an edge-mode request. Without auto-EOI it sets the in-service bit. With auto-EOI (`auto_eoi` bit 0 primary, bit 1 secondary) and rotation enabled, it makes the accepted level the lowest priority instead.
- R10: `eoi_valid` clears the in-service bit of line `eoi_line`, with bit 3 picking the controller. With rotation enabled, it also makes that level the lowest priority.
- R11: When no winner exists, `vec_valid` is 0 and `vec_out` is 0. This includes a primary winner of line 2 with no secondary winner.
- R12: A high-then-low pulse on a level-mode line leaves its request clear. A low-then-high pulse on a line that was low sets its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_op_valid | input | 1 | Line command strobe |
| line_op_num | input | 4 | Line number 0..15 |
| line_op_kind | input | 2 | 0 set high, 1 set low, 2 high-then-low pulse, 3 low-then-high pulse |
| elc_wr_en | input | 1 | Trigger-mode register write strobe |
| elc_wr_sel | input | 1 | Write target: 0 primary, 1 secondary |
| elc_wdata | input | 8 | Trigger-mode write data |
| elc_rd_sel | input | 1 | Read target: 0 primary, 1 secondary |
| elc_rdata | output | 8 | Trigger-mode read data |
| pri_vec_base | input | 8 | Primary vector base (bits 7:3 used) |
| sec_vec_base | input | 8 | Secondary vector base (bits 7:3 used) |
| pri_mask | input | 8 | Primary line masks, 1 = masked |
| sec_mask | input | 8 | Secondary line masks, 1 = masked |
| auto_eoi | input | 2 | Auto-EOI per controller |
| rotate_on | input | 2 | Rotation per controller |
| eoi_valid | input | 1 | Specific end-of-interrupt strobe |
| eoi_line | input | 4 | Line whose in-service bit clears |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_vector | input | 8 | Acknowledged vector |
| intr_out | output | 1 | Interrupt request to processor |
| vec_valid | output | 1 | Pending vector is valid |
| vec_out | output | 8 | Pending vector |

## Verification
The bench builds the block with its default parameters: eight lines per controller, 8-bit vectors, and allow masks of 0xF8 and 0xDE. With these values, the hard-wired edge lines 0–2 and 8 can be reached, and lines 3–7 can be switched to level mode. The 5-bit base compare used to route a cascade acknowledge is exercised with bases 0x20 and 0x28. A three-step rotation sequence with auto-EOI becomes observable through the pending vector.

// File: rtl/dual_pic_pkg.sv
package dual_pic_pkg;
    localparam int CHIP_LINES = 8;
    localparam int LVL_W      = $clog2(CHIP_LINES);
    localparam int LINE_W     = LVL_W + 1;
    localparam int VEC_W      = 8;
    localparam logic [LVL_W-1:0] CASCADE_LVL = LVL_W'(2);

    typedef enum logic {
        ST_IDLE,
        ST_EVAL
    } eval_state_t;

    typedef enum logic [1:0] {
        OP_SET_HIGH   = 2'd0,
        OP_SET_LOW    = 2'd1,
        OP_PULSE_RISE = 2'd2,
        OP_PULSE_FALL = 2'd3
    } line_op_t;
endpackage

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0]         mask,
    input  logic [N-1:0]         service,
    input  logic [$clog2(N)-1:0] lowprio,
    output logic                 found,
    output logic [$clog2(N)-1:0] level
);
    localparam int LW = $clog2(N);

    logic [LW-1:0] idx;
    logic          stop;

    always_comb begin
        found = 1'b0;
        level = '0;
        stop  = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            idx = lowprio + LW'(i + 1);
            if (!stop) begin
                if (service[idx]) begin
                    stop = 1'b1;
                end else if (req[idx] && !mask[idx]) begin
                    found = 1'b1;
                    level = idx;
                    stop  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pic_trigger_regs.sv
module pic_trigger_regs #(
    parameter int             W         = 8,
    parameter logic [W-1:0]   PRI_ALLOW = 8'hF8,
    parameter logic [W-1:0]   SEC_ALLOW = 8'hDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [W-1:0]      wdata,
    input  logic              rd_sel,
    output logic [1:0][W-1:0] level_mode,
    output logic [W-1:0]      rdata
);
    localparam logic [1:0][W-1:0] ALLOW = {SEC_ALLOW, PRI_ALLOW};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_mode <= '0;
        end else if (wr_en) begin
            for (int c = 0; c < 2; c++) begin
                if (wr_sel == 1'(c)) level_mode[c] <= wdata & ALLOW[c];
            end
        end
    end

    assign rdata = level_mode[rd_sel];
endmodule

// File: rtl/dual_pic_core.sv
module dual_pic_core
    import dual_pic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_op_valid,
    input  logic [LINE_W-1:0]  line_op_num,
    input  logic [1:0]         line_op_kind,
    input  logic               elc_wr_en,
    input  logic               elc_wr_sel,
    input  logic [CHIP_LINES-1:0] elc_wdata,
    input  logic               elc_rd_sel,
    output logic [CHIP_LINES-1:0] elc_rdata,
    input  logic [VEC_W-1:0]   pri_vec_base,
    input  logic [VEC_W-1:0]   sec_vec_base,
    input  logic [CHIP_LINES-1:0] pri_mask,
    input  logic [CHIP_LINES-1:0] sec_mask,
    input  logic [1:0]         auto_eoi,
    input  logic [1:0]         rotate_on,
    input  logic               eoi_valid,
    input  logic [LINE_W-1:0]  eoi_line,
    input  logic               ack_valid,
    input  logic [VEC_W-1:0]   ack_vector,
    output logic               intr_out,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_out
);
    logic [1:0][CHIP_LINES-1:0] req_q, req_n, pin_q, pin_n, isr_q, isr_n;
    logic [1:0][CHIP_LINES-1:0] level_mode, mask_now, mask_q;
    logic [1:0][LVL_W-1:0]      lowp_q, lowp_n;
    logic [1:0]                 raised_q, raised_n;
    eval_state_t                state_q, state_n;
    logic                       eval_on, change_evt;

    logic                       view_found [2];
    logic [LVL_W-1:0]           view_lvl   [2];
    logic [CHIP_LINES-1:0]      pri_eval_req;
    logic                       pri_eval_found;
    logic [LVL_W-1:0]           pri_eval_lvl;
    logic                       cascade_now, pri_raise, sec_hit;
    logic [1:0]                 acc_hit;
    logic [1:0][LVL_W-1:0]      acc_lvl;

    logic                       lc;
    logic [LVL_W-1:0]           ll;
    logic [1:0]                 s1, step;

    assign mask_now = {sec_mask, pri_mask};

    pic_trigger_regs #(.W(CHIP_LINES)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (elc_wr_en),
        .wr_sel     (elc_wr_sel),
        .wdata      (elc_wdata),
        .rd_sel     (elc_rd_sel),
        .level_mode (level_mode),
        .rdata      (elc_rdata)
    );

    // Per-controller view of the current state: drives the vector output
    // and the secondary half of the evaluation.
    for (genvar c = 0; c < 2; c++) begin : g_view
        pic_prio_pick #(.N(CHIP_LINES)) u_pick (
            .req     (req_q[c]),
            .mask    (mask_now[c]),
            .service (isr_q[c]),
            .lowprio (lowp_q[c]),
            .found   (view_found[c]),
            .level   (view_lvl[c])
        );
    end

    // Primary evaluation sees the cascade pulse produced in the same cycle.
    assign cascade_now  = eval_on && view_found[1] && !raised_q[1];
    assign pri_eval_req = req_q[0] |
        ((cascade_now && !pin_q[0][CASCADE_LVL]) ? (CHIP_LINES'(1) << CASCADE_LVL) : '0);

    pic_prio_pick #(.N(CHIP_LINES)) u_pri_eval (
        .req     (pri_eval_req),
        .mask    (mask_now[0]),
        .service (isr_q[0]),
        .lowprio (lowp_q[0]),
        .found   (pri_eval_found),
        .level   (pri_eval_lvl)
    );

    assign pri_raise = eval_on && pri_eval_found && !raised_q[0];

    // Acknowledge routing
    assign sec_hit    = ack_vector[VEC_W-1:LVL_W] == sec_vec_base[VEC_W-1:LVL_W];
    assign acc_hit[1] = ack_valid && sec_hit;
    assign acc_lvl[1] = ack_vector[LVL_W-1:0];
    assign acc_hit[0] = ack_valid;
    assign acc_lvl[0] = sec_hit ? CASCADE_LVL : ack_vector[LVL_W-1:0];

    function automatic logic [1:0] pin_step(input logic old_pin, input logic old_req,
                                            input logic lvl_trig, input logic new_lvl);
        logic set_r, clr_r;
        set_r = new_lvl && (!old_pin || lvl_trig);
        clr_r = !new_lvl && old_pin && lvl_trig;
        return {new_lvl, set_r ? 1'b1 : (clr_r ? 1'b0 : old_req)};
    endfunction

    // Next-state of the request/service/pointer state
    always_comb begin
        req_n    = req_q;
        pin_n    = pin_q;
        isr_n    = isr_q;
        lowp_n   = lowp_q;
        raised_n = raised_q;
        lc       = line_op_num[LVL_W];
        ll       = line_op_num[LVL_W-1:0];
        s1       = '0;
        step     = {pin_q[lc][ll], req_q[lc][ll]};

        if (line_op_valid) begin
            unique case (line_op_t'(line_op_kind))
                OP_SET_HIGH: step = pin_step(pin_q[lc][ll], req_q[lc][ll], level_mode[lc][ll], 1'b1);
                OP_SET_LOW:  step = pin_step(pin_q[lc][ll], req_q[lc][ll], level_mode[lc][ll], 1'b0);
                OP_PULSE_RISE: begin
                    s1   = pin_step(pin_q[lc][ll], req_q[lc][ll], level_mode[lc][ll], 1'b1);
                    step = pin_step(s1[1], s1[0], level_mode[lc][ll], 1'b0);
                end
                OP_PULSE_FALL: begin
                    s1   = pin_step(pin_q[lc][ll], req_q[lc][ll], level_mode[lc][ll], 1'b0);
                    step = pin_step(s1[1], s1[0], level_mode[lc][ll], 1'b1);
                end
            endcase
            pin_n[lc][ll] = step[1];
            req_n[lc][ll] = step[0];
        end

        for (int c = 0; c < 2; c++) begin
            if (acc_hit[c]) begin
                raised_n[c] = 1'b0;
                if (!level_mode[c][acc_lvl[c]]) req_n[c][acc_lvl[c]] = 1'b0;
                if (auto_eoi[c]) begin
                    if (rotate_on[c]) lowp_n[c] = acc_lvl[c];
                end else begin
                    isr_n[c][acc_lvl[c]] = 1'b1;
                end
            end
        end

        if (eoi_valid) begin
            isr_n[eoi_line[LVL_W]][eoi_line[LVL_W-1:0]] = 1'b0;
            if (rotate_on[eoi_line[LVL_W]]) lowp_n[eoi_line[LVL_W]] = eoi_line[LVL_W-1:0];
        end

        if (cascade_now) begin
            raised_n[1] = 1'b1;
            if (!pin_q[0][CASCADE_LVL]) req_n[0][CASCADE_LVL] = 1'b1;
            pin_n[0][CASCADE_LVL] = 1'b0;
        end
        if (pri_raise) raised_n[0] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q    <= '0;
            pin_q    <= '0;
            isr_q    <= '0;
            lowp_q   <= '1;
            raised_q <= '0;
            mask_q   <= '1;
        end else begin
            req_q    <= req_n;
            pin_q    <= pin_n;
            isr_q    <= isr_n;
            lowp_q   <= lowp_n;
            raised_q <= raised_n;
            mask_q   <= mask_now;
        end
    end

    // Evaluation scheduler
    assign change_evt = line_op_valid | ack_valid | eoi_valid | elc_wr_en | (mask_now != mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (change_evt) state_n = ST_EVAL;
            ST_EVAL: state_n = change_evt ? ST_EVAL : ST_IDLE;
        endcase
    end

    always_comb begin
        eval_on   = (state_q == ST_EVAL);
        intr_out  = raised_q[0];
        vec_valid = 1'b0;
        vec_out   = '0;
        if (view_found[0]) begin
            if (view_lvl[0] != CASCADE_LVL) begin
                vec_valid = 1'b1;
                vec_out   = {pri_vec_base[VEC_W-1:LVL_W], view_lvl[0]};
            end else if (view_found[1]) begin
                vec_valid = 1'b1;
                vec_out   = {sec_vec_base[VEC_W-1:LVL_W], view_lvl[1]};
            end
        end
    end

    // R6: once raised, the processor request holds until an acknowledge
    a_r6_intr_held: assert property (@(posedge clk) disable iff (!rst_n)
        intr_out && !ack_valid |=> intr_out);

    // R6: the request can only rise out of an evaluation cycle
    a_r6_intr_after_eval: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intr_out) |-> $past(eval_on));

    // R5: the secondary raised flag is only set by an evaluation
    a_r5_cascade_after_eval: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raised_q[1]) |-> $past(eval_on));

    // R11: a valid vector needs a stored primary request
    a_r11_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (req_q[0] != '0));

    // R8: a secondary acknowledge books primary level 2 in service
    a_r8_split_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid && sec_hit && !auto_eoi[0] && !eoi_valid |=> isr_q[0][CASCADE_LVL]);
endmodule

// File: tb/dual_pic_core_tb.sv
module dual_pic_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_op_valid = 1'b0;
    logic [3:0] line_op_num = '0;
    logic [1:0] line_op_kind = '0;
    logic       elc_wr_en = 1'b0;
    logic       elc_wr_sel = 1'b0;
    logic [7:0] elc_wdata = '0;
    logic       elc_rd_sel = 1'b0;
    logic [7:0] elc_rdata;
    logic [7:0] pri_vec_base = 8'h20;
    logic [7:0] sec_vec_base = 8'h28;
    logic [7:0] pri_mask = 8'hFF;
    logic [7:0] sec_mask = 8'hFF;
    logic [1:0] auto_eoi = '0;
    logic [1:0] rotate_on = '0;
    logic       eoi_valid = 1'b0;
    logic [3:0] eoi_line = '0;
    logic       ack_valid = 1'b0;
    logic [7:0] ack_vector = '0;
    logic       intr_out;
    logic       vec_valid;
    logic [7:0] vec_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [9:0] q_exp [$];
    bit         q_mode [$];
    string      q_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_pic_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .line_op_valid(line_op_valid), .line_op_num(line_op_num), .line_op_kind(line_op_kind),
        .elc_wr_en(elc_wr_en), .elc_wr_sel(elc_wr_sel), .elc_wdata(elc_wdata),
        .elc_rd_sel(elc_rd_sel), .elc_rdata(elc_rdata),
        .pri_vec_base(pri_vec_base), .sec_vec_base(sec_vec_base),
        .pri_mask(pri_mask), .sec_mask(sec_mask),
        .auto_eoi(auto_eoi), .rotate_on(rotate_on),
        .eoi_valid(eoi_valid), .eoi_line(eoi_line),
        .ack_valid(ack_valid), .ack_vector(ack_vector),
        .intr_out(intr_out), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    // Monitor: pops expected items and compares shortly after each falling edge
    always @(negedge clk) begin
        #1;
        if (q_exp.size() > 0) begin
            logic [9:0] e, a;
            bit         m;
            string      t;
            e = q_exp.pop_front();
            m = q_mode.pop_front();
            t = q_tag.pop_front();
            a = m ? {2'b00, elc_rdata} : {intr_out, vec_valid, vec_out};
            total++;
            if (a !== e) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", t, a, e);
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic line_op(input logic [3:0] n, input logic [1:0] k);
        line_op_num = n; line_op_kind = k; line_op_valid = 1'b1;
        @(negedge clk);
        line_op_valid = 1'b0;
        step();
    endtask

    task automatic ack(input logic [7:0] v);
        ack_vector = v; ack_valid = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0;
        step();
    endtask

    task automatic eoi(input logic [3:0] n);
        eoi_line = n; eoi_valid = 1'b1;
        @(negedge clk);
        eoi_valid = 1'b0;
        step();
    endtask

    task automatic elc_write(input logic sel, input logic [7:0] d);
        elc_wr_sel = sel; elc_wdata = d; elc_wr_en = 1'b1;
        @(negedge clk);
        elc_wr_en = 1'b0;
        step();
    endtask

    task automatic expect_out(input string tag, input logic i, input logic v, input logic [7:0] vec);
        q_exp.push_back({i, v, vec});
        q_mode.push_back(1'b0);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic expect_elc(input string tag, input logic sel, input logic [7:0] val);
        elc_rd_sel = sel;
        q_exp.push_back({2'b00, val});
        q_mode.push_back(1'b1);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // reset state
        expect_out("R11 reset idle", 1'b0, 1'b0, 8'h00);
        expect_elc("R4 primary mode reset", 1'b0, 8'h00);
        expect_elc("R4 secondary mode reset", 1'b1, 8'h00);

        // R7 masked line is not eligible
        line_op(4'd3, 2'd0);
        expect_out("R7 masked line ignored", 1'b0, 1'b0, 8'h00);
        pri_mask = 8'h00; sec_mask = 8'h00;
        step(); step();
        expect_out("R1 R6 unmask gives vector 0x23", 1'b1, 1'b1, 8'h23);
        line_op(4'd5, 2'd0);
        expect_out("R7 lower level keeps priority", 1'b1, 1'b1, 8'h23);
        ack(8'h23);
        expect_out("R7 in-service blocks lower level", 1'b0, 1'b0, 8'h00);
        eoi(4'd3);
        expect_out("R10 eoi releases next request", 1'b1, 1'b1, 8'h25);
        ack(8'h25);
        eoi(4'd5);
        expect_out("R11 nothing left pending", 1'b0, 1'b0, 8'h00);

        // R2 edge detection
        line_op(4'd5, 2'd0);
        expect_out("R2 no edge when already high", 1'b0, 1'b0, 8'h00);
        line_op(4'd5, 2'd1);
        expect_out("R2 low on edge line sets nothing", 1'b0, 1'b0, 8'h00);
        line_op(4'd5, 2'd0);
        expect_out("R2 new rising edge", 1'b1, 1'b1, 8'h25);
        ack(8'h25);
        eoi(4'd5);
        line_op(4'd3, 2'd1);
        line_op(4'd5, 2'd1);
        expect_out("R2 falling edge leaves edge line idle", 1'b0, 1'b0, 8'h00);

        // R4 hard-wired edge bits
        elc_write(1'b0, 8'hFF);
        expect_elc("R4 primary write masked", 1'b0, 8'hF8);
        elc_write(1'b1, 8'hFF);
        expect_elc("R4 secondary write masked", 1'b1, 8'hDE);

        // R3 level detection
        line_op(4'd4, 2'd0);
        expect_out("R3 level high requests", 1'b1, 1'b1, 8'h24);
        ack(8'h24);
        expect_out("R3 in service after ack", 1'b0, 1'b0, 8'h00);
        eoi(4'd4);
        expect_out("R3 level request survives ack", 1'b1, 1'b1, 8'h24);
        line_op(4'd4, 2'd1);
        expect_out("R3 R6 low clears, intr held", 1'b1, 1'b0, 8'h00);
        ack(8'h27);
        eoi(4'd7);
        expect_out("R6 ack drops intr", 1'b0, 1'b0, 8'h00);

        // R12 pulses
        line_op(4'd6, 2'd2);
        expect_out("R12 rise pulse on level line", 1'b0, 1'b0, 8'h00);
        line_op(4'd6, 2'd3);
        expect_out("R12 fall pulse sets request", 1'b1, 1'b1, 8'h26);
        line_op(4'd6, 2'd1);
        ack(8'h26);
        eoi(4'd6);
        expect_out("R12 cleanup idle", 1'b0, 1'b0, 8'h00);

        // R5 cascade through primary line 2
        line_op_num = 4'd8; line_op_kind = 2'd0; line_op_valid = 1'b1;
        @(negedge clk);
        line_op_valid = 1'b0;
        expect_out("R6 R5 not yet evaluated", 1'b0, 1'b0, 8'h00);
        expect_out("R5 R1 cascade vector", 1'b1, 1'b1, 8'h28);
        ack(8'h28);
        expect_out("R8 split ack clears both", 1'b0, 1'b0, 8'h00);
        line_op(4'd3, 2'd0);
        expect_out("R8 primary level 2 in service", 1'b0, 1'b0, 8'h00);
        eoi(4'd2);
        expect_out("R8 R10 eoi level 2 frees line 3", 1'b1, 1'b1, 8'h23);
        ack(8'h23);
        line_op(4'd3, 2'd1);
        eoi(4'd3);
        eoi(4'd8);
        expect_out("R8 cleanup idle", 1'b0, 1'b0, 8'h00);

        // R9 auto-EOI with rotation
        auto_eoi = 2'b01; rotate_on = 2'b01;
        line_op(4'd4, 2'd0);
        line_op(4'd6, 2'd0);
        expect_out("R9 initial winner", 1'b1, 1'b1, 8'h24);
        ack(8'h24);
        expect_out("R9 rotation after level 4", 1'b1, 1'b1, 8'h26);
        ack(8'h26);
        expect_out("R9 rotation after level 6", 1'b1, 1'b1, 8'h24);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R6: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule